// File: doc/BRIEF.md
# Rotating LED Shift Display

This block holds a ring of bits that drives a row of LEDs directly. One bit is set after reset. On every step event the whole pattern moves one place, toward the most significant bit or toward the least significant bit, as a direction input selects. The bit that leaves one end comes back in at the other end, so exactly one LED stays lit.

A step event comes from one of two sources, and a mode input picks which one. The first source is a push button. It passes through two flip-flops in series, and a rising edge gives a pulse one clock long. The second source is a divider that counts system clock cycles and gives a one-cycle tick once per period. With the default count the period is about 2 Hz on a 50 MHz clock. Everything runs on the single system clock. A synchronous, active-high reset reloads the seed pattern and wins over a step that arrives in the same cycle.

Top module: `shift_display_top`

## Requirements
- R1: While `rst` is high at a clock edge, `led` becomes 0x01 (only bit 0 set) after that edge.
- R2: With `auto_mode` = 0, each 0-to-1 change of `btn_step` moves the pattern exactly once. The move shows on `led` after the second clock edge that samples the button high. Holding the button high, or keeping it low, moves nothing more.
- R3: With `dir_left` = 1, a step moves every bit one place toward the MSB, and bit 7 re-enters at bit 0 (0x80 becomes 0x01).
- R4: With `dir_left` = 0, a step moves every bit one place toward the LSB, and bit 0 re-enters at bit 7 (0x01 becomes 0x80).
- R5: With `auto_mode` = 1, the pattern moves once every `TICK_CYCLES` clock cycles. After reset is released, the first move shows after clock edge `TICK_CYCLES`+1.
- R6: With `auto_mode` = 1, the button has no effect. With `auto_mode` = 0, the internal tick has no effect.
- R7: A reset and a step in the same cycle give the seed 0x01, not a moved pattern.
- R8: Outside reset, exactly one bit of `led` is set at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the only clock of the block |
| rst | input | 1 | Synchronous active-high reset; loads the seed pattern |
| btn_step | input | 1 | Step push button; asynchronous, level high while pressed |
| auto_mode | input | 1 | 1 selects the internal tick as step source, 0 selects the button |
| dir_left | input | 1 | 1 moves toward the MSB, 0 moves toward the LSB |
| led | output | 8 | Registered ring pattern, one bit per LED |

## Verification
The bench builds the block with `TICK_CYCLES` = 8 in place of the count of tens of millions used on hardware. Auto-stepping, and its exact phase after reset, can then be checked over several periods in a few dozen cycles. The width stays at 8, so nine presses in each direction carry the set bit through both wrap points. Toggling the button during auto mode, and waiting several tick periods in button mode, shows that each source is shut out when it is not selected.

// File: rtl/shift_display_pkg.sv
package shift_display_pkg;
  typedef enum logic {
    ROT_TOWARD_LSB = 1'b0,
    ROT_TOWARD_MSB = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/btn_edge_pulse.sv
module btn_edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic pulse
);
  logic samp_new;
  logic samp_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_new <= 1'b0;
      samp_old <= 1'b0;
    end else begin
      samp_new <= btn_raw;
      samp_old <= samp_new;
    end
  end

  // one clock long on a rising edge of the synchronised button
  assign pulse = samp_new & ~samp_old;
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_shifter.sv
module ring_shifter
  import shift_display_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  rot_dir_e         dir,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int LO = (i + WIDTH - 1) % WIDTH;
    localparam int HI = (i + 1) % WIDTH;
    assign nxt[i] = (dir == ROT_TOWARD_MSB) ? q[LO] : q[HI];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else if (step) q <= nxt;
  end
endmodule

// File: rtl/shift_display_top.sv
module shift_display_top
  import shift_display_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_step,
  input  logic             auto_mode,
  input  logic             dir_left,
  output logic [WIDTH-1:0] led
);
  logic btn_pulse;
  logic tick;
  logic step;
  rot_dir_e dir;

  btn_edge_pulse u_edge (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (btn_step),
    .pulse   (btn_pulse)
  );

  tick_divider #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  assign step = auto_mode ? tick : btn_pulse;
  assign dir  = dir_left ? ROT_TOWARD_MSB : ROT_TOWARD_LSB;

  ring_shifter #(.WIDTH(WIDTH)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .dir  (dir),
    .q    (led)
  );
endmodule

// File: rtl/shift_display_chk.sv
module shift_display_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             auto_mode,
  input logic             dir_left,
  input logic             step,
  input logic             btn_pulse,
  input logic [WIDTH-1:0] led
);
  // R1
  a_r1_seed_on_reset: assert property (@(posedge clk)
    rst |=> led == WIDTH'(1));

  // R3
  a_r3_rotate_msb: assert property (@(posedge clk) disable iff (rst)
    (step && dir_left) |=> led == {$past(led[WIDTH-2:0]), $past(led[WIDTH-1])});

  // R4
  a_r4_rotate_lsb: assert property (@(posedge clk) disable iff (rst)
    (step && !dir_left) |=> led == {$past(led[0]), $past(led[WIDTH-1:1])});

  // R2
  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(led));

  // R2
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    btn_pulse |=> !btn_pulse);

  // R8
  a_r8_one_lit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(led) == 1);
endmodule

bind shift_display_top shift_display_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .auto_mode (auto_mode),
  .dir_left  (dir_left),
  .step      (step),
  .btn_pulse (btn_pulse),
  .led       (led)
);

// File: tb/sim_shift_display_top.sv
module sim_shift_display_top;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int TICK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_step = 1'b0;
  logic auto_mode = 1'b0;
  logic dir_left = 1'b1;
  logic [W-1:0] led;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] exp_led;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_display_top #(.WIDTH(W), .TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst(rst), .btn_step(btn_step),
    .auto_mode(auto_mode), .dir_left(dir_left), .led(led)
  );

  function automatic logic [W-1:0] rot(input logic [W-1:0] v, input logic left);
    if (left) return {v[W-2:0], v[W-1]};
    return {v[0], v[W-1:1]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: led=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    btn_step = 1'b0;
    edges(2);
    rst = 1'b0;
    exp_led = 8'h01;
  endtask

  task automatic press();
    btn_step = 1'b1;
    edges(1);
    check("R2 no move after first sampling edge", led, exp_led);
    edges(1);
    exp_led = rot(exp_led, dir_left);
    check("R2 move after second edge", led, exp_led);
    edges(3);
    check("R2 hold gives no further move", led, exp_led);
    btn_step = 1'b0;
    edges(3);
  endtask

  task automatic test_reset();
    auto_mode = 1'b0;
    do_reset();
    check("R1 reset seed", led, 8'h01);
  endtask

  task automatic test_left_wrap();
    auto_mode = 1'b0;
    dir_left = 1'b1;
    do_reset();
    for (int k = 0; k < 9; k++) begin
      press();
      check("R3 rotate toward MSB with wrap", led, exp_led);
    end
    check("R3 back to 0x02 after nine moves", led, 8'h02);
  endtask

  task automatic test_right_wrap();
    auto_mode = 1'b0;
    dir_left = 1'b0;
    do_reset();
    press();
    check("R4 0x01 wraps to 0x80", led, 8'h80);
    for (int k = 0; k < 8; k++) begin
      press();
      check("R4 rotate toward LSB", led, exp_led);
    end
    check("R4 at 0x80 after nine moves", led, 8'h80);
  endtask

  task automatic test_tick_ignored();
    auto_mode = 1'b0;
    dir_left = 1'b1;
    do_reset();
    edges(4 * TICK);
    check("R6 tick ignored in button mode", led, 8'h01);
  endtask

  task automatic test_auto();
    auto_mode = 1'b1;
    dir_left = 1'b1;
    do_reset();
    edges(TICK);
    check("R5 no move before first tick", led, exp_led);
    edges(1);
    exp_led = rot(exp_led, 1'b1);
    check("R5 first auto move", led, exp_led);
    for (int k = 0; k < 4; k++) begin
      btn_step = ~btn_step;
      edges(TICK - 1);
      check("R6 button ignored in auto mode", led, exp_led);
      edges(1);
      exp_led = rot(exp_led, 1'b1);
      check("R5 periodic auto move", led, exp_led);
    end
    btn_step = 1'b0;
    dir_left = 1'b0;
    edges(TICK);
    exp_led = rot(exp_led, 1'b0);
    check("R5 auto move toward LSB", led, exp_led);
  endtask

  task automatic test_reset_priority();
    auto_mode = 1'b0;
    dir_left = 1'b1;
    do_reset();
    press();
    press();
    btn_step = 1'b1;
    edges(1);
    rst = 1'b1;
    btn_step = 1'b0;
    edges(1);
    rst = 1'b0;
    check("R7 reset wins over same-cycle step", led, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_left_wrap();
    test_right_wrap();
    test_tick_ignored();
    test_auto();
    test_reset_priority();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule